// File: doc/BRIEF.md
# Register-Accessed CRC-16 Calculator

This block is a small CRC-16 engine that software drives through a 16-bit register port. Software clears it, writes the message one byte per register write, and then reads back both the 16-bit checksum and the number of bytes folded in so far. It serves as a start-up self-test of the checksum logic and as a software-driven frame checker.

Three registers are decoded from a 2-bit word select. Register 0 is the control word: writing a 1 in bit 15 clears the engine, and a read returns the byte count. Register 1 takes the input byte. Register 2 returns the checksum. Each byte is folded in within the clock cycle of its write. A read of any register returns data from a combinational multiplexer, so the value is valid in the same cycle the select is applied.

Top module: `crc16_reg_engine`

## Requirements
- R1: After rst_ni is asserted low, the control register (sel 0) reads 0x0000 and the result register (sel 2) reads 0x0000, because the internal state is 0xFFFF and is read out inverted.
- R2: A write to sel 0 with bit 15 set returns the internal state to 0xFFFF and the byte count to 0. Afterwards the count reads 0 and the result reads 0x0000.
- R3: A write to sel 0 with bit 15 clear leaves both the checksum and the count unchanged.
- R4: A read of sel 0 returns the byte count in bits 11:0 and zero in bits 15:12.
- R5: Each write to sel 1 raises the byte count by one.
- R6: A write to sel 1 folds in only wdata_i[7:0]. Bits 15:8 of that write do not affect the checksum.
- R7: The checksum uses the reflected polynomial 0x8408. Bits are taken least significant first and the state starts at 0xFFFF. Sel 2 reads the bitwise inverse of the state.
- R8: When sel 2 is read in the cycle after a data write, the result already includes that byte.
- R9: After a clear followed by the bytes 0xCC, 0xF5, 0xF1 and 0xA7, the count reads 4 and the result reads 0x51DF.
- R10: The count stops at 0xFFF and does not wrap. Data writes made after that point still change the checksum.
- R11: Writes to sel 2 or sel 3 change nothing, and a read of sel 3 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register word select (0 control, 1 data, 2 result, 3 unused) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register |

## Verification
The engine is first run on the fixed check vector. It then receives long runs of random bytes whose upper write bits are also random, so a design that folds the upper bits or processes bits in the wrong order gives a different checksum from the bench model. Clears are placed at random points, which separates a correct restart from stale state carried across the clear. Control writes without bit 15 and writes to the read-only and unused selects show whether any stray write changes state. More than 4095 data writes drive the count into saturation, which tells a saturating counter apart from a wrapping one and confirms that the checksum keeps advancing while the count holds.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned SEL_W  = 2;
  localparam logic [WORD_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [WORD_W-1:0] STATE_INIT = 16'hFFFF;
  localparam logic [WORD_W-1:0] OUT_XOR = 16'hFFFF;
  localparam int unsigned CLR_BIT = 15;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_RESULT = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/crc16_fold.sv
module crc16_fold #(
  parameter int unsigned W = 16,
  parameter int unsigned B = 8,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic [W-1:0] crc_i,
  input  logic [B-1:0] byte_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [0:B];

  assign stage[0] = crc_i ^ {{(W-B){1'b0}}, byte_i};

  // one shift-and-reduce step per input bit, LSB first
  for (genvar i = 0; i < B; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
  end

  assign crc_o = stage[B];
endmodule

// File: rtl/crc16_sat_cnt.sv
module crc16_sat_cnt #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/crc16_reg_engine.sv
module crc16_reg_engine
  import crc16_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned CW = CNT_W,
  parameter logic [DW-1:0] POLY = POLY_REFL,
  parameter logic [DW-1:0] INIT = STATE_INIT,
  parameter logic [DW-1:0] XOUT = OUT_XOR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PAD_W = DW - CW;

  reg_sel_e      sel;
  logic          clr, feed;
  logic [DW-1:0] crc_q, crc_next;
  logic [CW-1:0] cnt_q;
  logic          unused_wbits;

  assign sel  = reg_sel_e'(sel_i);
  assign clr  = wr_en_i && (sel == SEL_CTRL) && wdata_i[CLR_BIT];
  assign feed = wr_en_i && (sel == SEL_DATA);
  assign unused_wbits = ^wdata_i[DW-2:BW];

  crc16_fold #(.W(DW), .B(BW), .POLY(POLY)) u_fold (
    .crc_i  (crc_q),
    .byte_i (wdata_i[BW-1:0]),
    .crc_o  (crc_next)
  );

  crc16_sat_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (feed),
    .cnt_o  (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= INIT;
    else if (clr)  crc_q <= INIT;
    else if (feed) crc_q <= crc_next;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rdata_o = {{PAD_W{1'b0}}, cnt_q};
      SEL_RESULT: rdata_o = crc_q ^ XOUT;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crc16_reg_engine_chk.sv
module crc16_reg_engine_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    sel_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] crc_q,
  input logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic do_clr, do_feed;
  assign do_clr  = wr_en_i && sel_i == 2'd0 && wdata_i[15];
  assign do_feed = wr_en_i && sel_i == 2'd1;

  // R2
  clear_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_clr |=> (cnt_q == '0 && crc_q == 16'hFFFF));

  // R3
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!do_clr && !do_feed) |=> ($stable(crc_q) && $stable(cnt_q)));

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_feed && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R10
  count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX && !do_clr) |=> cnt_q == CMAX);

  // R4
  ctrl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0) |-> rdata_o[DW-1:CW] == '0);
endmodule

bind crc16_reg_engine crc16_reg_engine_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .sel_i   (sel_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .crc_q   (crc_q),
  .cnt_q   (cnt_q)
);

// File: tb/sim_crc16_reg_engine.sv
`timescale 1ns/1ps
module sim_crc16_reg_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_crc;
  int          m_cnt;
  bit          done = 0;

  always #10 clk_i = ~clk_i;

  crc16_reg_engine u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [15:0] fold(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (s == 2'd0 && d[15]) begin m_crc = 16'hFFFF; m_cnt = 0; end
    if (s == 2'd1) begin
      m_crc = fold(m_crc, d[7:0]);
      if (m_cnt < 4095) m_cnt++;
    end
  endtask

  task automatic rd(logic [1:0] s, output logic [15:0] v);
    wr_en_i = 1'b0; sel_i = s;
    #1 v = rdata_o;
  endtask

  task automatic check_state(string req);
    logic [15:0] v;
    rd(2'd0, v); check(req, v, 16'(m_cnt));
    rd(2'd2, v); check(req, v, ~m_crc);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    m_crc = 16'hFFFF; m_cnt = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1", v, 16'h0000);
    rd(2'd2, v); check("R1", v, 16'h0000);

    // R9 check vector
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R9", v, 16'd4);
    rd(2'd2, v); check("R9", v, 16'h51DF);

    // R3 control write without clear bit
    wr(2'd0, 16'h7FFF);
    check_state("R3");
    // R11 writes to result and spare ignored
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'h1234);
    check_state("R11");
    rd(2'd3, v); check("R11", v, 16'h0000);

    // R2 clear restarts
    wr(2'd0, 16'h8000);
    check_state("R2");
    rd(2'd2, v); check("R2", v, 16'h0000);

    // R6 upper bits ignored: same byte, different upper bits, same result
    wr(2'd1, 16'hA55A);
    rd(2'd2, v); check("R6", v, ~fold(16'hFFFF, 8'h5A));
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h005A);
    rd(2'd2, v); check("R6", v, ~fold(16'hFFFF, 8'h5A));

    // R7 R8 R5 random bytes with random clears, result checked right after each write
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 19) == 0) wr(2'd0, 16'(16'h8000 | $urandom_range(0, 16'h7FFF)));
      else if ($urandom_range(0, 9) == 0) wr(2'd0, 16'($urandom_range(0, 16'h7FFF)));
      else wr(2'd1, 16'($urandom_range(0, 16'hFFFF)));
      rd(2'd2, v); check("R8", v, ~m_crc);
      rd(2'd0, v); check("R5", v, 16'(m_cnt));
    end
    rd(2'd0, v); check("R4", {v[15:12], 12'h000}, 16'h0000);

    // R10 saturation
    wr(2'd0, 16'h8000);
    for (int n = 0; n < 4095; n++) wr(2'd1, 16'($urandom_range(0, 16'hFFFF)));
    check_state("R10");
    for (int n = 0; n < 3; n++) begin
      wr(2'd1, 16'($urandom_range(0, 16'hFFFF)));
      check_state("R10");
    end
    rd(2'd0, v); check("R4", v, 16'h0FFF);
    wr(2'd0, 16'h8000);
    check_state("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule